// File: doc/BRIEF.md
# Timer Capture/Compare Channel Register

This block is the 16-bit value register of one timer channel. When the channel mode is capture, a strobe from the edge detector copies the free-running counter into the register. Otherwise the register holds a match value, and the block raises a one-clock pulse when the counter reaches that value. Software reaches the register over an 8-bit bus as two byte locations. The upper byte sits at a parameterised base address and the lower byte at the next address up.

A 16-bit value that crosses an 8-bit bus can tear, so the block guards against it. Reading the upper byte freezes the register against captures until the lower byte is read. This keeps the two halves from being split by a capture that lands between the reads. Writing the upper byte holds off compare matches until the lower byte is written. This keeps a half-written match value from firing. Any change of mode cancels a pending hold.

The counter, the edge detector, pin actions, flags and interrupts sit outside this block.

Top module: `tcc_channel`

## Requirements
- R1: A mode value of 2'b00 selects capture. Any of 2'b01, 2'b10 or 2'b11 selects compare. In compare mode a capture strobe leaves the stored value unchanged.
- R2: In capture mode, with no hold pending, a capture strobe stores the counter value at that clock edge. Reading the register afterwards returns it.
- R3: In capture mode, a read of the upper byte blocks captures from that same cycle on. A capture that arrives in the same cycle as the upper-byte read is also blocked. Blocked captures are dropped, not queued.
- R4: A read of the lower byte ends the capture hold after that cycle. A capture strobe that arrives in the same cycle as the lower-byte read is still dropped.
- R5: The upper byte (bits 15:8) is at address HI_ADDR and the lower byte (bits 7:0) at HI_ADDR+1. Reads of any other address return 0, and writes to any other address change nothing. When no read strobe is active, the read data is 0.
- R6: A bus write loads only the addressed byte, in either mode. A bus write takes priority over a capture strobe in the same cycle, and that capture is dropped.
- R7: In compare mode, with no hold pending, the match output is high for exactly one clock, in the cycle after a clock edge at which the counter equals the stored value. The match output never rises in capture mode.
- R8: In compare mode, a write of the upper byte suppresses matches until the lower byte has been written. This holds both for the new value and for the old one.
- R9: A change of the mode input clears both the capture hold and the compare hold.
- R10: Reset clears both holds and drives the match output low. The stored value is undefined until it is first loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode_sel | input | 2 | Channel mode, 2'b00 capture, other values compare |
| counter_val | input | 16 | Free-running counter value |
| capture_evt | input | 1 | One-cycle capture strobe from the edge detector |
| bus_addr | input | 8 | Bus address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational during the read strobe |
| cmp_match | output | 1 | One-clock compare-match pulse |

## Verification
The bench builds the block with the default parameters: byte width 8, address width 8 and base address 0x14. This gives a 16-bit register at 0x14 and 0x15. Writes and reads at the adjacent addresses 0x13 and 0x16 then exercise the decoder at both edges of the decoded pair. Because the counter is driven directly by the bench, each bus strobe can be placed in the exact cycle of a capture strobe or of a counter match. That reaches the same-cycle cases: upper-byte read against capture, lower-byte read against capture, and write against capture.

// File: rtl/tcc_pkg.sv
`timescale 1ns/1ps
package tcc_pkg;

  typedef enum logic [1:0] {
    MODE_CAPTURE = 2'b00,
    MODE_CMP_1   = 2'b01,
    MODE_CMP_2   = 2'b10,
    MODE_CMP_3   = 2'b11
  } chan_mode_e;

  function automatic logic mode_is_capture(input logic [1:0] m);
    return m == MODE_CAPTURE;
  endfunction

endpackage

// File: rtl/tcc_bus_port.sv
`timescale 1ns/1ps
module tcc_bus_port #(
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 8,
  parameter logic [ADDR_W-1:0] HI_ADDR = 'h14,
  localparam int VAL_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [VAL_W-1:0]  chan_value,
  output logic              rd_hi,
  output logic              rd_lo,
  output logic              wr_hi,
  output logic              wr_lo,
  output logic [BYTE_W-1:0] bus_rdata
);

  localparam logic [ADDR_W-1:0] LO_ADDR = HI_ADDR + 1'b1;

  function automatic logic [BYTE_W-1:0] get_byte(input logic [VAL_W-1:0] v,
                                                 input logic upper);
    return upper ? v[VAL_W-1:BYTE_W] : v[BYTE_W-1:0];
  endfunction

  logic hit_hi;
  logic hit_lo;

  assign hit_hi = bus_addr == HI_ADDR;
  assign hit_lo = bus_addr == LO_ADDR;
  assign rd_hi  = bus_rd & hit_hi;
  assign rd_lo  = bus_rd & hit_lo;
  assign wr_hi  = bus_wr & hit_hi;
  assign wr_lo  = bus_wr & hit_lo;

  always_comb begin
    bus_rdata = '0;
    if (rd_hi) begin
      bus_rdata = get_byte(chan_value, 1'b1);
    end else if (rd_lo) begin
      bus_rdata = get_byte(chan_value, 1'b0);
    end
  end

  // R5
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_hi, rd_lo}) && $onehot0({wr_hi, wr_lo}));

endmodule

// File: rtl/tcc_inhibit.sv
`timescale 1ns/1ps
module tcc_inhibit
  import tcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  input  logic       rd_hi,
  input  logic       rd_lo,
  input  logic       wr_hi,
  input  logic       wr_lo,
  output logic       cap_inhibit,
  output logic       cmp_inhibit,
  output logic       mode_change
);

  chan_mode_e mode_q;
  logic       capture_mode;
  logic       cap_next;
  logic       cmp_next;

  assign capture_mode = mode_is_capture(mode_sel);
  assign mode_change  = chan_mode_e'(mode_sel) != mode_q;

  always_comb begin
    cap_next = cap_inhibit;
    if (mode_change) begin
      cap_next = 1'b0;
    end else if (rd_lo) begin
      cap_next = 1'b0;
    end else if (rd_hi && capture_mode) begin
      cap_next = 1'b1;
    end
  end

  always_comb begin
    cmp_next = cmp_inhibit;
    if (mode_change) begin
      cmp_next = 1'b0;
    end else if (wr_lo) begin
      cmp_next = 1'b0;
    end else if (wr_hi && !capture_mode) begin
      cmp_next = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= MODE_CAPTURE;
      cap_inhibit <= 1'b0;
      cmp_inhibit <= 1'b0;
    end else begin
      mode_q      <= chan_mode_e'(mode_sel);
      cap_inhibit <= cap_next;
      cmp_inhibit <= cmp_next;
    end
  end

  // R9
  mode_clears_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_change |=> !cap_inhibit && !cmp_inhibit);

  // R3
  hi_read_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hi && capture_mode && !mode_change && !rd_lo) |=> cap_inhibit);

  // R8
  hi_write_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !capture_mode && !mode_change) |=> cmp_inhibit);

endmodule

// File: rtl/tcc_value_reg.sv
`timescale 1ns/1ps
module tcc_value_reg
  import tcc_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int VAL_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_sel,
  input  logic              capture_evt,
  input  logic [VAL_W-1:0]  counter_val,
  input  logic              rd_hi,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              cap_inhibit,
  output logic              cap_load,
  output logic [VAL_W-1:0]  value_q
);

  function automatic logic [VAL_W-1:0] put_byte(input logic [VAL_W-1:0] cur,
                                                 input logic upper,
                                                 input logic [BYTE_W-1:0] b);
    logic [VAL_W-1:0] r;
    r = cur;
    if (upper) r[VAL_W-1:BYTE_W] = b;
    else       r[BYTE_W-1:0]     = b;
    return r;
  endfunction

  logic             cap_blocked;
  logic [VAL_W-1:0] written;

  assign cap_blocked = cap_inhibit | rd_hi | wr_hi | wr_lo;
  assign cap_load    = capture_evt & mode_is_capture(mode_sel) & ~cap_blocked;

  always_comb begin
    written = value_q;
    if (wr_hi) written = put_byte(written, 1'b1, wdata);
    if (wr_lo) written = put_byte(written, 1'b0, wdata);
  end

  always_ff @(posedge clk) begin
    if (wr_hi || wr_lo) begin
      value_q <= written;
    end else if (cap_load) begin
      value_q <= counter_val;
    end
  end

  // R2
  capture_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_load |=> value_q == $past(counter_val));

  // R3
  frozen_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_inhibit && !wr_hi && !wr_lo) |=> $stable(value_q));

endmodule

// File: rtl/tcc_compare.sv
`timescale 1ns/1ps
module tcc_compare
  import tcc_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int VAL_W = 2 * BYTE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic [VAL_W-1:0] counter_val,
  input  logic [VAL_W-1:0] value_q,
  input  logic             cmp_inhibit,
  output logic             cmp_match
);

  function automatic logic count_hits(input logic [VAL_W-1:0] c,
                                      input logic [VAL_W-1:0] v);
    return (c ^ v) == '0;
  endfunction

  logic cmp_fire;

  assign cmp_fire = !mode_is_capture(mode_sel) && !cmp_inhibit &&
                    count_hits(counter_val, value_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_match <= 1'b0;
    else        cmp_match <= cmp_fire;
  end

  // R7
  match_needs_cmp_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_match |-> $past(mode_sel) != 2'b00);

  // R8
  match_held_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_inhibit |=> !cmp_match);

endmodule

// File: rtl/tcc_channel.sv
`timescale 1ns/1ps
module tcc_channel #(
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 8,
  parameter logic [ADDR_W-1:0] HI_ADDR = 'h14,
  localparam int VAL_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_sel,
  input  logic [VAL_W-1:0]  counter_val,
  input  logic              capture_evt,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              cmp_match
);

  logic             rd_hi;
  logic             rd_lo;
  logic             wr_hi;
  logic             wr_lo;
  logic             cap_inhibit;
  logic             cmp_inhibit;
  logic             mode_change;
  logic             cap_load;
  logic [VAL_W-1:0] chan_value;

  tcc_bus_port #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .HI_ADDR(HI_ADDR)) u_bus (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .chan_value (chan_value),
    .rd_hi      (rd_hi),
    .rd_lo      (rd_lo),
    .wr_hi      (wr_hi),
    .wr_lo      (wr_lo),
    .bus_rdata  (bus_rdata)
  );

  tcc_inhibit u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_sel    (mode_sel),
    .rd_hi       (rd_hi),
    .rd_lo       (rd_lo),
    .wr_hi       (wr_hi),
    .wr_lo       (wr_lo),
    .cap_inhibit (cap_inhibit),
    .cmp_inhibit (cmp_inhibit),
    .mode_change (mode_change)
  );

  tcc_value_reg #(.BYTE_W(BYTE_W)) u_value (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_sel    (mode_sel),
    .capture_evt (capture_evt),
    .counter_val (counter_val),
    .rd_hi       (rd_hi),
    .wr_hi       (wr_hi),
    .wr_lo       (wr_lo),
    .wdata       (bus_wdata),
    .cap_inhibit (cap_inhibit),
    .cap_load    (cap_load),
    .value_q     (chan_value)
  );

  tcc_compare #(.BYTE_W(BYTE_W)) u_cmp (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_sel    (mode_sel),
    .counter_val (counter_val),
    .value_q     (chan_value),
    .cmp_inhibit (cmp_inhibit),
    .cmp_match   (cmp_match)
  );

  // R5
  unaddressed_keeps_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hi && !wr_lo && !cap_load) |=> $stable(chan_value));

  // R5
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_hi && !rd_lo) |-> bus_rdata == '0);

  // R1
  no_capture_in_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel != 2'b00) |-> !cap_load);

endmodule

// File: tb/tcc_channel_test.sv
`timescale 1ns/1ps
module tcc_channel_test;

  localparam logic [7:0] HI = 8'h14;
  localparam logic [7:0] LO = 8'h15;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode_sel;
  logic [15:0] counter_val;
  logic        capture_evt;
  logic [7:0]  bus_addr;
  logic        bus_rd;
  logic        bus_wr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic        cmp_match;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  tcc_channel uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_sel    (mode_sel),
    .counter_val (counter_val),
    .capture_evt (capture_evt),
    .bus_addr    (bus_addr),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .cmp_match   (cmp_match)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_op(input logic rd, input logic wr, input logic [7:0] a,
                        input logic [7:0] d, input logic cap, output logic [7:0] rv);
    @(negedge clk);
    bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = d; capture_evt = cap;
    #1 rv = bus_rdata;
    @(posedge clk);
    #1 bus_rd = 1'b0; bus_wr = 1'b0; capture_evt = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] a, input logic [7:0] d);
    logic [7:0] rv;
    bus_op(1'b0, 1'b1, a, d, 1'b0, rv);
  endtask

  task automatic rd_byte(input logic [7:0] a, output logic [7:0] rv);
    bus_op(1'b1, 1'b0, a, 8'h00, 1'b0, rv);
  endtask

  task automatic capture(input logic [15:0] c);
    logic [7:0] rv;
    counter_val = c;
    bus_op(1'b0, 1'b0, 8'h00, 8'h00, 1'b1, rv);
  endtask

  task automatic read_word(output logic [15:0] w);
    logic [7:0] h;
    logic [7:0] l;
    rd_byte(HI, h);
    rd_byte(LO, l);
    w = {h, l};
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    mode_sel = m;
    @(negedge clk);
  endtask

  task automatic expect_match(input logic [15:0] v, input logic exp, input string req);
    @(negedge clk);
    counter_val = v;
    @(negedge clk);
    chk(req, {15'd0, cmp_match}, {15'd0, exp});
    counter_val = v + 16'd1;
    if (exp) begin
      @(negedge clk);
      chk(req, {15'd0, cmp_match}, 16'd0);
    end
  endtask

  task automatic t_reset;
    #1;
    chk("R10 match low", {15'd0, cmp_match}, 16'd0);
    chk("R10 idle rdata", {8'd0, bus_rdata}, 16'd0);
  endtask

  task automatic t_capture_basic;
    logic [15:0] w;
    set_mode(2'b00);
    capture(16'h1234);
    read_word(w);
    chk("R2 capture value", w, 16'h1234);
  endtask

  task automatic t_capture_in_cmp;
    logic [15:0] w;
    set_mode(2'b01);
    wr_byte(HI, 8'hBE);
    wr_byte(LO, 8'hEF);
    capture(16'h1111);
    read_word(w);
    chk("R1 capture ignored in compare", w, 16'hBEEF);
  endtask

  task automatic t_hi_read_freeze;
    logic [7:0] b;
    logic [15:0] w;
    set_mode(2'b00);
    capture(16'h1234);
    rd_byte(HI, b);
    chk("R3 upper byte", {8'd0, b}, 16'h0012);
    capture(16'h5678);
    rd_byte(LO, b);
    chk("R3 coherent lower byte", {8'd0, b}, 16'h0034);
    read_word(w);
    chk("R4 dropped capture not queued", w, 16'h1234);
    capture(16'h9ABC);
    read_word(w);
    chk("R4 capture after release", w, 16'h9ABC);
  endtask

  task automatic t_same_cycle_hi;
    logic [7:0] b;
    logic [15:0] w;
    counter_val = 16'h4321;
    bus_op(1'b1, 1'b0, HI, 8'h00, 1'b1, b);
    chk("R3 same-cycle upper read", {8'd0, b}, 16'h009A);
    rd_byte(LO, b);
    chk("R3 same-cycle capture dropped", {8'd0, b}, 16'h00BC);
    read_word(w);
    chk("R3 value after same-cycle", w, 16'h9ABC);
  endtask

  task automatic t_same_cycle_lo;
    logic [7:0] b;
    logic [15:0] w;
    rd_byte(HI, b);
    counter_val = 16'h0F0F;
    bus_op(1'b1, 1'b0, LO, 8'h00, 1'b1, b);
    chk("R4 lower read with capture", {8'd0, b}, 16'h00BC);
    read_word(w);
    chk("R4 capture at release dropped", w, 16'h9ABC);
    capture(16'h0F0F);
    read_word(w);
    chk("R4 next capture accepted", w, 16'h0F0F);
  endtask

  task automatic t_decode;
    logic [7:0] b;
    logic [15:0] w;
    wr_byte(HI + 8'd2, 8'h55);
    wr_byte(HI - 8'd1, 8'h66);
    read_word(w);
    chk("R5 neighbour writes ignored", w, 16'h0F0F);
    rd_byte(HI + 8'd2, b);
    chk("R5 read above range", {8'd0, b}, 16'h0000);
    rd_byte(HI - 8'd1, b);
    chk("R5 read below range", {8'd0, b}, 16'h0000);
    #1 chk("R5 rdata idle", {8'd0, bus_rdata}, 16'h0000);
  endtask

  task automatic t_write_priority;
    logic [7:0] rv;
    logic [15:0] w;
    counter_val = 16'hFFFF;
    bus_op(1'b0, 1'b1, HI, 8'h77, 1'b1, rv);
    read_word(w);
    chk("R6 upper write beats capture", w, 16'h770F);
    bus_op(1'b0, 1'b1, LO, 8'h88, 1'b1, rv);
    read_word(w);
    chk("R6 lower write beats capture", w, 16'h7788);
  endtask

  task automatic t_compare;
    set_mode(2'b01);
    wr_byte(HI, 8'h40);
    wr_byte(LO, 8'h00);
    expect_match(16'h4000, 1'b1, "R7 match pulse");
    expect_match(16'h3FFF, 1'b0, "R7 no match off value");
    set_mode(2'b00);
    expect_match(16'h4000, 1'b0, "R7 no match in capture");
  endtask

  task automatic t_cmp_inhibit;
    set_mode(2'b11);
    wr_byte(HI, 8'h50);
    expect_match(16'h5000, 1'b0, "R8 held on new value");
    expect_match(16'h4000, 1'b0, "R8 held on old value");
    wr_byte(LO, 8'h10);
    expect_match(16'h5010, 1'b1, "R8 match after lower write");
  endtask

  task automatic t_mode_clear;
    logic [7:0] b;
    logic [15:0] w;
    set_mode(2'b01);
    wr_byte(HI, 8'h60);
    set_mode(2'b10);
    expect_match(16'h6010, 1'b1, "R9 compare hold cleared");
    set_mode(2'b00);
    rd_byte(HI, b);
    set_mode(2'b01);
    set_mode(2'b00);
    capture(16'hABCD);
    read_word(w);
    chk("R9 capture hold cleared", w, 16'hABCD);
  endtask

  initial begin
    rst_n = 1'b0;
    mode_sel = 2'b00;
    counter_val = 16'h0000;
    capture_evt = 1'b0;
    bus_addr = 8'h00;
    bus_rd = 1'b0;
    bus_wr = 1'b0;
    bus_wdata = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_capture_basic();
    t_capture_in_cmp();
    t_hi_read_freeze();
    t_same_cycle_hi();
    t_same_cycle_lo();
    t_decode();
    t_write_priority();
    t_compare();
    t_cmp_inhibit();
    t_mode_clear();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog R10 actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule